// File: doc/BRIEF.md
# Set/Clear GPIO Port with Auto-Direction

This block is a 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus and connects to a pad wrapper through per-pin output-enable and output-data signals. It also takes the raw pin inputs from that wrapper. Software never writes the output latch directly. Instead it writes ones to a set register or to a clear register. Either of those writes also turns the addressed pins into outputs in the same access, so no separate direction write is needed.

A separate write-one-to-tristate register returns pins to input mode. Three of the offsets carry one meaning for reads and another for writes. The tristate offset reads back the input-mode mask. The set offset reads back the output latch. The pin-level offset reads the synchronized pin levels, and a write to it enables the per-pin input path.

Pin inputs pass through a two-flop synchronizer before software can read them. Register reads are captured one cycle after the request and are held until the next read.

Top module: `gpio_setclr_port`

## Requirements
- R1: After synchronous reset, all pins are in input mode: `pad_oe` is 0, `pad_out` is 0, a read of offset 0x100 returns 0xFFFFFFFF, and reads of offsets 0x108 and 0x110 return 0.
- R2: A write to offset 0x100 puts every pin whose data bit is 1 into input mode, so its `pad_oe` bit becomes 0. The output latch is not changed by this write.
- R3: A write to offset 0x108 sets the latch bit of every pin whose data bit is 1, and switches each such pin to output mode (`pad_oe` bit 1) in the same access.
- R4: A write to offset 0x10C clears the latch bit of every pin whose data bit is 1, and switches each such pin to output mode in the same access.
- R5: Zero bits in a write to offset 0x100, 0x108, 0x10C or 0x110 leave the direction, latch and input-enable state of the corresponding pins unchanged.
- R6: A write to offset 0x110 enables the input path of every pin whose data bit is 1. Input enables are cleared only by reset. A read of offset 0x110 returns each synchronized pin level ANDed with that pin's input enable.
- R7: Pin inputs pass through two flops. A `pad_in` change applied just before clock edge k is returned by a read sampled at edge k+2. Reads sampled at edges k and k+1 still return the old level.
- R8: `bus_rdata` is registered. It takes the value addressed by a read one clock after `bus_rd` is sampled, and it holds that value while no read is issued. Offset 0x100 reads the input-mode mask (1 = input). Offset 0x108 reads the output latch.
- R9: A read of any other offset, including 0x10C, returns 0. A write to any other offset changes no state.
- R10: `pad_oe` is the inverse of the input-mode mask. `pad_out` always follows the output latch, whatever the pin's direction.

Offsets are byte addresses matched on all `ADDR_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pin levels from the pad wrapper |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output data |

## Verification
- **Writes:** A write takes effect at the clock edge that samples `bus_wr`. The bench therefore compares `pad_oe` and `pad_out` at the falling edge that follows that edge.
- **Register reads:** Read data is due one edge after the strobe. Each read is sampled at the next falling edge, and back-to-back reads land on consecutive edges.
- **Pin levels:** A pin change needs two further edges before a read can see it. The bench waits at least three cycles after a random pin change before it compares levels. A directed case issues three reads in a row from the cycle of the change and expects old, old, new.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    // Register selected by the current bus address
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_TRI  = 3'd1,
        SEL_SET  = 3'd2,
        SEL_CLR  = 3'd3,
        SEL_LVL  = 3'd4
    } gsc_sel_e;

    // One-cycle write strobes into the pin bank
    typedef struct packed {
        logic to_input;
        logic drive_high;
        logic drive_low;
        logic in_enable;
    } gsc_wstb_s;

    // Turn a decoded selection plus a write strobe into the strobe struct
    function automatic gsc_wstb_s gsc_strobes(input gsc_sel_e sel, input logic wr);
        gsc_wstb_s s;
        s.to_input   = wr && (sel == SEL_TRI);
        s.drive_high = wr && (sel == SEL_SET);
        s.drive_low  = wr && (sel == SEL_CLR);
        s.in_enable  = wr && (sel == SEL_LVL);
        return s;
    endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFS_TRI = 'h100,
    parameter logic [ADDR_W-1:0] OFS_SET = 'h108,
    parameter logic [ADDR_W-1:0] OFS_CLR = 'h10C,
    parameter logic [ADDR_W-1:0] OFS_LVL = 'h110
) (
    input  logic [ADDR_W-1:0] addr,
    output gsc_sel_e          sel
);
    always_comb begin
        if (addr == OFS_TRI)      sel = SEL_TRI;
        else if (addr == OFS_SET) sel = SEL_SET;
        else if (addr == OFS_CLR) sel = SEL_CLR;
        else if (addr == OFS_LVL) sel = SEL_LVL;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_sc_pinbank.sv
module gpio_sc_pinbank
    import gpio_sc_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  gsc_wstb_s       stb,
    input  logic [NPIN-1:0] wdata,
    output logic [NPIN-1:0] tri_q,
    output logic [NPIN-1:0] lat_q,
    output logic [NPIN-1:0] ien_q
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic hit_in, hit_hi, hit_lo, hit_en;
        assign hit_in = stb.to_input   && wdata[i];
        assign hit_hi = stb.drive_high && wdata[i];
        assign hit_lo = stb.drive_low  && wdata[i];
        assign hit_en = stb.in_enable  && wdata[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                tri_q[i] <= 1'b1;
                lat_q[i] <= 1'b0;
                ien_q[i] <= 1'b0;
            end else begin
                if (hit_hi || hit_lo) tri_q[i] <= 1'b0;
                else if (hit_in)      tri_q[i] <= 1'b1;
                if (hit_hi)           lat_q[i] <= 1'b1;
                else if (hit_lo)      lat_q[i] <= 1'b0;
                if (hit_en)           ien_q[i] <= 1'b1;
            end
        end

        // R3: a set write drives the pin high and makes it an output
        a_r3_set_drives: assert property (@(posedge clk) disable iff (rst)
            (stb.drive_high && wdata[i]) |=> (lat_q[i] && !tri_q[i]));
        // R4: a clear write drives the pin low and makes it an output
        a_r4_clr_drives: assert property (@(posedge clk) disable iff (rst)
            (stb.drive_low && wdata[i]) |=> (!lat_q[i] && !tri_q[i]));
        // R2: a tristate write makes the pin an input and keeps its latch
        a_r2_tri_keeps_latch: assert property (@(posedge clk) disable iff (rst)
            (stb.to_input && wdata[i]) |=> (tri_q[i] && $stable(lat_q[i])));
        // R5: without a one in this bit position, the pin's state holds
        a_r5_zero_bit_holds: assert property (@(posedge clk) disable iff (rst)
            !wdata[i] |=> ($stable(tri_q[i]) && $stable(lat_q[i]) && $stable(ien_q[i])));
        // R6: input enables never drop once set
        a_r6_ien_sticky: assert property (@(posedge clk) disable iff (rst)
            ien_q[i] |=> ien_q[i]);
    end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPIN   = 32,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] OFS_TRI = 'h100,
    parameter logic [ADDR_W-1:0] OFS_SET = 'h108,
    parameter logic [ADDR_W-1:0] OFS_CLR = 'h10C,
    parameter logic [ADDR_W-1:0] OFS_LVL = 'h110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPIN-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_out
);
    gsc_sel_e        sel;
    gsc_wstb_s       stb;
    logic [NPIN-1:0] tri_q, lat_q, ien_q, lvl_sync;
    logic [NPIN-1:0] rd_next;

    gpio_sc_decode #(
        .ADDR_W(ADDR_W), .OFS_TRI(OFS_TRI), .OFS_SET(OFS_SET),
        .OFS_CLR(OFS_CLR), .OFS_LVL(OFS_LVL)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    assign stb = gsc_strobes(sel, bus_wr);

    gpio_sc_pinbank #(.NPIN(NPIN)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .wdata(bus_wdata),
        .tri_q(tri_q),
        .lat_q(lat_q),
        .ien_q(ien_q)
    );

    gpio_sc_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pad_in),
        .q  (lvl_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_TRI: rd_next = tri_q;
            SEL_SET: rd_next = lat_q;
            SEL_LVL: rd_next = lvl_sync & ien_q;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    assign pad_oe  = ~tri_q;
    assign pad_out = lat_q;

    // R9: reads of unmapped offsets return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
    // R8: read data holds while no read is issued
    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
    // R10: a pin driven through set/clear is an output
    a_r10_oe_after_drive: assert property (@(posedge clk) disable iff (rst)
        (stb.drive_high || stb.drive_low) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));
endmodule

// File: tb/gpio_setclr_port_bench.sv
module gpio_setclr_port_bench;
    localparam logic [11:0] A_TRI = 12'h100;
    localparam logic [11:0] A_SET = 12'h108;
    localparam logic [11:0] A_CLR = 12'h10C;
    localparam logic [11:0] A_LVL = 12'h110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_tri, m_lat, m_ien;

    always #2 clk = ~clk;

    gpio_setclr_port u_gpio_setclr_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == A_TRI) return m_tri;
        if (a == A_SET) return m_lat;
        if (a == A_LVL) return pad_in & m_ien;
        return 32'h0;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == A_TRI) m_tri = m_tri | d;
        else if (a == A_SET) begin m_lat = m_lat | d; m_tri = m_tri & ~d; end
        else if (a == A_CLR) begin m_lat = m_lat & ~d; m_tri = m_tri & ~d; end
        else if (a == A_LVL) m_ien = m_ien | d;
    endfunction

    // Tasks start and end at a falling edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        chk(req, pad_oe, ~m_tri);
        chk(req, pad_out, m_lat);
    endtask

    task automatic check_regs(input string req);
        logic [31:0] r;
        bus_read(A_TRI, r); chk(req, r, exp_read(A_TRI));
        bus_read(A_SET, r); chk(req, r, exp_read(A_SET));
        bus_read(A_LVL, r); chk(req, r, exp_read(A_LVL));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, hold;
        logic [11:0] addrs [7];
        void'($urandom(32'd20240611));
        addrs = '{A_TRI, A_SET, A_CLR, A_LVL, 12'h104, 12'h000, 12'h114};
        m_tri = '1; m_lat = '0; m_ien = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 out", pad_out, 32'h0);
        pad_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        bus_read(A_TRI, r); chk("R1 tri", r, 32'hFFFF_FFFF);
        bus_read(A_SET, r); chk("R1 latch", r, 32'h0);
        bus_read(A_LVL, r); chk("R1 level disabled", r, 32'h0);

        // R3 set drives and switches to output
        bus_write(A_SET, 32'h0000_00F0);
        check_pads("R3 set");
        // R4 clear on other pins switches them to output low
        bus_write(A_CLR, 32'h0000_0F00);
        check_pads("R4 clr");
        chk("R4 oe", pad_oe, 32'h0000_0FF0);
        // R5 zero bits hold; partial clear
        bus_write(A_CLR, 32'h0000_0030);
        chk("R5 out", pad_out, 32'h0000_00C0);
        chk("R5 oe", pad_oe, 32'h0000_0FF0);
        // R2 tristate keeps the latch; R10 pad_out follows latch in input mode
        bus_write(A_TRI, 32'h0000_00C0);
        chk("R2 oe", pad_oe, 32'h0000_0F30);
        chk("R10 out while input", pad_out, 32'h0000_00C0);
        bus_read(A_SET, r); chk("R2 latch kept", r, 32'h0000_00C0);
        // R9 unmapped write ignored and unmapped read zero
        bus_write(12'h104, 32'hFFFF_FFFF);
        check_pads("R9 write ignored");
        bus_read(A_CLR, r); chk("R9 read clr zero", r, 32'h0);
        bus_read(12'h000, r); chk("R9 read other zero", r, 32'h0);
        // R8 hold without read
        hold = bus_rdata;
        bus_write(A_SET, 32'h1);
        repeat (2) @(negedge clk);
        chk("R8 hold", bus_rdata, hold);
        // R6 input enable
        bus_write(A_LVL, 32'h0000_FFFF);
        pad_in = 32'hA5A5_5A5A;
        repeat (3) @(negedge clk);
        bus_read(A_LVL, r); chk("R6 level masked", r, 32'h0000_5A5A);
        bus_write(A_LVL, 32'h0);
        bus_read(A_LVL, r); chk("R6 enables sticky", r, 32'h0000_5A5A);
        bus_write(A_LVL, 32'hFFFF_0000);
        // R7 synchronizer latency: old, old, new
        hold = pad_in;
        pad_in = ~hold;
        bus_read(A_LVL, r); chk("R7 edge k", r, hold);
        bus_read(A_LVL, r); chk("R7 edge k+1", r, hold);
        bus_read(A_LVL, r); chk("R7 edge k+2", r, ~hold);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                logic [11:0] a;
                a = addrs[$urandom_range(0, 6)];
                bus_write(a, $urandom());
                check_pads("R5 random write");
            end else if (op < 8) begin
                logic [11:0] a;
                a = addrs[$urandom_range(0, 6)];
                bus_read(a, r);
                chk("R8 random read", r, exp_read(a));
            end else begin
                pad_in = $urandom();
                repeat (3) @(negedge clk);
                bus_read(A_LVL, r);
                chk("R7 random level", r, exp_read(A_LVL));
            end
        end
        check_regs("R8 final");

        // R1 reset restores defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_tri = '1; m_lat = '0; m_ien = '0;
        @(negedge clk);
        check_pads("R1 re-reset");
        check_regs("R1 re-reset regs");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule